// File: doc/BRIEF.md
# Character LCD Nibble Bus Bridge

This block is a register-mapped bridge between a simple 32-bit processor bus and a character display module that is wired with a 4-bit data path. Software writes command or character nibbles into two registers. The bridge then runs one complete transfer on the display side. It drives the register-select and read/write lines and sets them up ahead of the enable strobe. It holds the strobe high for a programmable number of clocks, and it keeps driving the data nibble for a short hold window after the strobe falls.

Reading the command register starts a nibble read from the display. The bridge floats the data lanes, samples them in the last strobe-high cycle and keeps the nibble for software. A completion flag, an interrupt enable, a masked status bit and an interrupt output report when a transfer is done. The interrupt is raised only for the first nibble read of a byte. The second nibble read is started by reading the captured nibble, and software has to poll the raw flag to see it finish. While a transfer is running the bus is stalled.

Top module: `lcd_nibble_bridge`

## Requirements
- R1: After reset the enable strobe is low, the data lanes are not driven, the bus is ready, the raw flag and the enable bit read as zero and the interrupt is low.
- R2: A write to offset 0x00 starts a transfer with register-select low and read/write low. A write to offset 0x04 starts one with register-select high. In both cases the nibble driven on the data lanes is bits 7:4 of the write word.
- R3: The accepting clock edge is followed by SETUP_CYCLES cycles with the strobe low, then EN_CYCLES cycles with the strobe high, then HOLD_CYCLES cycles with the strobe low. Register-select and read/write stay stable for the whole transfer. In a write, the data lanes are driven from the cycle after acceptance to the end of the hold window.
- R4: A read of offset 0x00 starts a transfer with read/write high and the data lanes undriven. The nibble present in the last strobe-high cycle is captured and is returned in bits 7:4 of offset 0x08.
- R5: Bit 8 of offset 0x0C becomes 1 in the cycle after the last hold cycle, and it is cleared when any new transfer is accepted.
- R6: A write to offset 0x0C with bit 8 low clears the raw flag and drops the interrupt. A write with bit 8 high leaves the flag unchanged.
- R7: Bit 0 of offset 0x10 is the interrupt enable. Bit 0 of offset 0x14 reads the raw flag ANDed with the enable. The interrupt output is high when the raw flag and the enable are both set after any transfer other than a second nibble read.
- R8: A read of offset 0x08 right after a first nibble read has completed starts the second nibble read. When that read completes it sets the raw flag but leaves the interrupt low, even with the enable set. A later read of 0x08 starts no transfer.
- R9: While a transfer is in progress, ready is low and no bus access has any effect. A stalled access is accepted in the first cycle after the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request, held until ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid when selected and ready |
| bus_ready | output | 1 | Access completes at this edge when high |
| lcd_rs | output | 1 | Register select to the display |
| lcd_rw | output | 1 | Read (1) or write (0) to the display |
| lcd_en | output | 1 | Enable strobe |
| lcd_d_out | output | 4 | Data nibble to the display |
| lcd_d_oe | output | 1 | Output enable for the data lanes |
| lcd_d_in | input | 4 | Data nibble from the display |
| irq | output | 1 | Interrupt request |

## Verification
A wrong phase or count in the sequencer shows up in the cycle-by-cycle comparison of the strobe, the output enable and ready against an independent model within one cycle of the error. The model knows the cycle count since acceptance. The bench offers the correct nibble only in the last strobe-high cycle, so a capture that is one cycle off shows up at the next read of the read-back register. A flag that is set or cleared at the wrong time appears on the interrupt at once, or in the raw or status reads that follow each transfer. A wrong pair-tracking state appears as an interrupt after the second read, or as a transfer that should not start.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;

    localparam int NIB_W   = 4;
    localparam int NIB_LSB = 4;
    localparam int RAW_BIT = 8;

    // Word index of each register (byte address bits above 1:0)
    localparam int IDX_CMD = 0;
    localparam int IDX_DAT = 1;
    localparam int IDX_RDB = 2;
    localparam int IDX_RAW = 3;
    localparam int IDX_MSK = 4;
    localparam int IDX_STA = 5;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD
    } phase_t;

    typedef struct packed {
        logic             rs;
        logic             rd;
        logic             second;
        logic [NIB_W-1:0] nib;
    } xfer_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lcdb_seq.sv
module lcdb_seq
    import lcdb_pkg::*;
#(
    parameter int SETUP_CYCLES = 2,
    parameter int EN_CYCLES    = 24,
    parameter int HOLD_CYCLES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  xfer_t            req,
    input  logic [NIB_W-1:0] lcd_d_in,
    output logic             busy,
    output logic             done,
    output logic             done_second,
    output logic             done_rd,
    output logic [NIB_W-1:0] rd_nib,
    output logic             lcd_rs,
    output logic             lcd_rw,
    output logic             lcd_en,
    output logic [NIB_W-1:0] lcd_d_out,
    output logic             lcd_d_oe
);
    localparam int MAXC = max3(SETUP_CYCLES, EN_CYCLES, HOLD_CYCLES);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] S_LAST = CW'(SETUP_CYCLES - 1);
    localparam logic [CW-1:0] E_LAST = CW'(EN_CYCLES - 1);
    localparam logic [CW-1:0] H_LAST = CW'(HOLD_CYCLES - 1);

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last_cnt;
    logic          at_last;
    xfer_t         cur;

    always_comb begin
        case (phase)
            PH_SETUP: last_cnt = S_LAST;
            PH_PULSE: last_cnt = E_LAST;
            default:  last_cnt = H_LAST;
        endcase
        at_last = (cnt == last_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            cur    <= '0;
            rd_nib <= '0;
        end else begin
            if (phase == PH_IDLE) begin
                if (start) begin
                    phase <= PH_SETUP;
                    cnt   <= '0;
                    cur   <= req;
                end
            end else if (at_last) begin
                cnt <= '0;
                case (phase)
                    PH_SETUP: phase <= PH_PULSE;
                    PH_PULSE: phase <= PH_HOLD;
                    default:  phase <= PH_IDLE;
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (phase == PH_PULSE && at_last && cur.rd)
                rd_nib <= lcd_d_in;
        end
    end

    assign busy        = (phase != PH_IDLE);
    assign done        = (phase == PH_HOLD) && at_last;
    assign done_second = done && cur.second;
    assign done_rd     = done && cur.rd;
    assign lcd_rs      = cur.rs;
    assign lcd_rw      = cur.rd;
    assign lcd_en      = (phase == PH_PULSE);
    assign lcd_d_out   = cur.nib;
    assign lcd_d_oe    = busy && !cur.rd;

endmodule

// File: rtl/lcdb_regs.sv
module lcdb_regs
    import lcdb_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    input  logic              busy,
    input  logic              done,
    input  logic              done_second,
    input  logic              done_rd,
    input  logic [NIB_W-1:0]  rd_nib,
    output logic              start,
    output xfer_t             req,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             acc;
    logic             raw_flag;
    logic             irq_en;
    logic             irq_arm;
    logic             pair_open;

    assign idx       = bus_addr[ADDR_W-1:2];
    assign bus_ready = !busy;
    assign acc       = bus_sel && !busy;

    always_comb begin
        start = 1'b0;
        req   = '0;
        if (acc) begin
            if (bus_wr) begin
                if (idx == IDX_W'(IDX_CMD) || idx == IDX_W'(IDX_DAT)) begin
                    start   = 1'b1;
                    req.rs  = (idx == IDX_W'(IDX_DAT));
                    req.nib = bus_wdata[NIB_LSB +: NIB_W];
                end
            end else if (idx == IDX_W'(IDX_CMD)) begin
                start  = 1'b1;
                req.rd = 1'b1;
            end else if (idx == IDX_W'(IDX_RDB) && pair_open) begin
                start      = 1'b1;
                req.rd     = 1'b1;
                req.second = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_flag  <= 1'b0;
            irq_en    <= 1'b0;
            irq_arm   <= 1'b0;
            pair_open <= 1'b0;
        end else begin
            if (start) begin
                raw_flag  <= 1'b0;
                pair_open <= 1'b0;
            end
            if (done) begin
                raw_flag  <= 1'b1;
                irq_arm   <= !done_second;
                pair_open <= done_rd && !done_second;
            end
            if (acc && bus_wr && idx == IDX_W'(IDX_RAW) && !bus_wdata[RAW_BIT])
                raw_flag <= 1'b0;
            if (acc && bus_wr && idx == IDX_W'(IDX_MSK))
                irq_en <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_W'(IDX_RDB): bus_rdata[NIB_LSB +: NIB_W] = rd_nib;
            IDX_W'(IDX_RAW): bus_rdata[RAW_BIT]          = raw_flag;
            IDX_W'(IDX_MSK): bus_rdata[0]                = irq_en;
            IDX_W'(IDX_STA): bus_rdata[0]                = raw_flag && irq_en;
            default:         bus_rdata                   = '0;
        endcase
    end

    assign irq = raw_flag && irq_en && irq_arm;

endmodule

// File: rtl/lcd_nibble_bridge.sv
module lcd_nibble_bridge
    import lcdb_pkg::*;
#(
    parameter int ADDR_W       = 5,
    parameter int DATA_W       = 32,
    parameter int SETUP_CYCLES = 2,
    parameter int EN_CYCLES    = 24,
    parameter int HOLD_CYCLES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_en,
    output logic [3:0]        lcd_d_out,
    output logic              lcd_d_oe,
    input  logic [3:0]        lcd_d_in,
    output logic              irq
);
    logic             busy;
    logic             done;
    logic             done_second;
    logic             done_rd;
    logic             start;
    xfer_t            req;
    logic [NIB_W-1:0] rd_nib;

    lcdb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .busy(busy), .done(done), .done_second(done_second), .done_rd(done_rd),
        .rd_nib(rd_nib), .start(start), .req(req), .irq(irq)
    );

    lcdb_seq #(
        .SETUP_CYCLES(SETUP_CYCLES), .EN_CYCLES(EN_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .req(req), .lcd_d_in(lcd_d_in),
        .busy(busy), .done(done), .done_second(done_second), .done_rd(done_rd),
        .rd_nib(rd_nib), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en),
        .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe)
    );

endmodule

// File: rtl/lcdb_checker.sv
module lcdb_checker #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready,
    input logic              lcd_rs,
    input logic              lcd_rw,
    input logic              lcd_en,
    input logic              lcd_d_oe,
    input logic              irq
);
    AST_STROBE_STALLS: assert property (@(posedge clk) disable iff (rst)
        lcd_en |-> !bus_ready);  // R9

    AST_LINES_STABLE: assert property (@(posedge clk) disable iff (rst)
        (lcd_en && $past(lcd_en)) |-> ($stable(lcd_rs) && $stable(lcd_rw)));  // R3

    AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_ready && bus_wr && bus_addr == ADDR_W'(0)) |=> (!bus_ready && !lcd_en && lcd_d_oe));  // R3

    AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_en) |-> !bus_ready);  // R3

    AST_READ_FLOATS: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_ready && !bus_wr && bus_addr == ADDR_W'(0)) |=> (lcd_rw && !lcd_d_oe));  // R4

    AST_RAW_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_ready && bus_wr && bus_addr == ADDR_W'(12) && !bus_wdata[8]) |=> !irq);  // R6
endmodule

bind lcd_nibble_bridge lcdb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_en(lcd_en), .lcd_d_oe(lcd_d_oe), .irq(irq)
);

// File: tb/lcd_nibble_bridge_test.sv
module lcd_nibble_bridge_test;
    localparam int S   = 2;
    localparam int E   = 24;
    localparam int H   = 2;
    localparam int TOT = S + E + H;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        lcd_rs, lcd_rw, lcd_en, lcd_d_oe, irq;
    logic [3:0]  lcd_d_out;
    logic [3:0]  lcd_d_in = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    bit       active = 0;
    int       age = 0;
    bit       kind_rd = 0, second_e = 0, rs_e = 0;
    bit [3:0] nib_e = 0, cap_e = 0, rd_value = 0;
    bit       raw_e = 0, mask_e = 0, arm_e = 0, pair_e = 0;
    bit       start_req = 0, req_rd = 0, req_second = 0, req_rs = 0;
    bit [3:0] req_nib = 0;

    always #10 clk = ~clk;

    lcd_nibble_bridge uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en), .lcd_d_out(lcd_d_out),
        .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            active = 0; raw_e = 0; mask_e = 0; arm_e = 0; pair_e = 0; cap_e = 0;
        end else if (start_req) begin
            active = 1; age = 0; raw_e = 0; pair_e = 0;
            kind_rd = req_rd; second_e = req_second; rs_e = req_rs;
            nib_e = req_rd ? 4'h0 : req_nib;
        end else if (active) begin
            if (kind_rd && age == S + E - 1) cap_e = rd_value;
            age++;
            if (age == TOT) begin
                active = 0; raw_e = 1; arm_e = !second_e;
                pair_e = kind_rd && !second_e;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(lcd_en === (active && age >= S && age < S + E), "R3 strobe", lcd_en, active && age >= S && age < S + E);
            chk(lcd_d_oe === (active && !kind_rd), "R3 data drive", lcd_d_oe, active && !kind_rd);
            chk(bus_ready === !active, "R9 ready", bus_ready, !active);
            chk(irq === (raw_e && mask_e && arm_e), "R7 irq", irq, raw_e && mask_e && arm_e);
            if (active) begin
                chk(lcd_rs === rs_e, "R2 rs", lcd_rs, rs_e);
                chk(lcd_rw === kind_rd, "R4 rw", lcd_rw, kind_rd);
                if (!kind_rd) chk(lcd_d_out === nib_e, "R2 nibble", lcd_d_out, nib_e);
            end
        end
        lcd_d_in = (active && kind_rd && age == S + E - 1) ? rd_value : ~rd_value;
    end

    task automatic access(input bit wr, input bit [4:0] a, input bit [31:0] d, output bit [31:0] q);
        @(negedge clk);
        bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1;
        while (!bus_ready) begin @(negedge clk); #1; end
        q = bus_rdata;
        req_rd = !wr; req_second = 0; req_rs = (a == 5'd4); req_nib = d[7:4];
        if (wr) start_req = (a == 5'd0 || a == 5'd4);
        else begin
            req_second = (a == 5'd8) && pair_e;
            start_req = (a == 5'd0) || req_second;
        end
        @(posedge clk); #1;
        bus_sel = 0; start_req = 0;
        if (wr && a == 5'd12 && !d[8]) raw_e = 0;
        if (wr && a == 5'd16) mask_e = d[0];
    endtask

    task automatic wr(input bit [4:0] a, input bit [31:0] d);
        bit [31:0] q;
        access(1, a, d, q);
    endtask

    task automatic rd_chk(input bit [4:0] a, input bit [31:0] exp, input string tag);
        bit [31:0] q;
        access(0, a, 0, q);
        chk(q === exp, tag, q, exp);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (active) @(negedge clk);
    endtask

    initial begin
        bit [31:0] q;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(lcd_en === 0 && lcd_d_oe === 0 && irq === 0 && bus_ready === 1, "R1 reset outputs", {lcd_en, lcd_d_oe, irq, bus_ready}, 4'b0001);
        rd_chk(5'd12, 32'h0, "R1 raw after reset");
        rd_chk(5'd16, 32'h0, "R1 enable after reset");

        // R7: enable, command write completes, interrupt and status
        wr(5'd16, 32'h1);
        wr(5'd0, 32'hA0);
        wait_idle();
        rd_chk(5'd20, 32'h1, "R7 status set");
        rd_chk(5'd12, 32'h100, "R5 raw after write");

        // R6: bit 8 high is ignored, bit 8 low clears
        wr(5'd12, 32'h100);
        rd_chk(5'd12, 32'h100, "R6 raw kept");
        wr(5'd12, 32'h0);
        rd_chk(5'd12, 32'h0, "R6 raw cleared");
        rd_chk(5'd20, 32'h0, "R6 status cleared");

        // R2/R9: data writes back to back; second is stalled
        wr(5'd4, 32'h5C);
        wr(5'd4, 32'h30);
        wait_idle();
        rd_chk(5'd12, 32'h100, "R9 stalled write completed");

        // R4/R8: nibble pair read
        rd_value = 4'h9;
        access(0, 5'd0, 0, q);
        wait_idle();
        rd_value = 4'h3;
        rd_chk(5'd8, 32'h90, "R4 first nibble");
        wait_idle();
        rd_chk(5'd12, 32'h100, "R8 raw after second read");
        chk(irq === 0, "R8 no irq on second", irq, 0);
        rd_chk(5'd20, 32'h1, "R7 status after second");
        rd_chk(5'd8, 32'h30, "R8 second nibble");
        rd_chk(5'd12, 32'h100, "R8 no further transfer");

        // R5: raw cleared at start; R7 enable off masks status
        wr(5'd16, 32'h0);
        rd_chk(5'd20, 32'h0, "R7 masked status");
        rd_value = 4'h6;
        access(0, 5'd0, 0, q);
        chk(irq === 0, "R5 irq low after start", irq, 0);
        wait_idle();
        rd_chk(5'd8, 32'h60, "R4 read with enable off");
        wait_idle();
        rd_chk(5'd20, 32'h0, "R7 status stays masked");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule